// File: doc/BRIEF.md
# ATAPI Packet Command Issuer

This block sends one command packet to a packet-interface storage device (typically an optical drive) over a simple register-access port onto the device's task file, using programmed I/O only. A controller places a 12-byte command on `pkt_bytes`, chooses whether the attached device expects 12-byte or 16-byte packets, sets a per-wait timeout and pulses `start`. The issuer then runs the whole sequence by itself. It waits for the device to go idle and writes the packet opcode to the command register. It polls until the device asks for data, streams the packet as 16-bit words into the data register, and finally polls until the device is idle again.

The machine has seven states. IDLE accepts `start`. PRECHK polls status until BSY is clear. CMD writes the opcode. DRQWAIT polls until BSY is clear and DRQ is set. WORD writes packet words. POSTWAIT polls until BSY is clear. FINISH asserts `done` for one cycle. The transitions are as follows:
- start: IDLE to PRECHK.
- ready: PRECHK to CMD.
- opcode written: CMD to DRQWAIT.
- data requested: DRQWAIT to WORD.
- word written: WORD to itself.
- last word: WORD to POSTWAIT.
- settled: POSTWAIT to FINISH.
- expired: any of the three polling states to FINISH.
- return: FINISH to IDLE.

Each access on the task-file port holds `tf_req` with stable address, direction and data until the device answers with a one-cycle `tf_ack`. Read data is valid in the `tf_ack` cycle. An ack that arrives while no access is outstanding is ignored.

Top module: `atapi_pkt_issuer`

## Requirements
- R1: After reset the block is idle: `busy`, `tf_req` and `done` are low, and while `busy` is low no access is requested.
- R2: After an accepted `start`, the block reads the status register (address 7). It writes nothing until a status read returns bit 7 (BSY) clear.
- R3: Exactly one command write per packet, to address 7 with value 0x00A0, before any data write.
- R4: No data write occurs until a status read has returned bit 7 clear and bit 3 (DRQ) set.
- R5: Packet words go to address 0. Word k carries packet byte 2k on bits 7..0 and byte 2k+1 on bits 15..8, where byte i is `pkt_bytes[8i+7:8i]`. A write request keeps its address and data until acknowledged.
- R6: With `long_pkt` = 0 exactly 6 words are written. With `long_pkt` = 1 exactly 8 words are written, the last two being 0x0000.
- R7: After the last word the block polls status until bit 7 is clear. It then pulses `done` for one cycle, with `fail` equal to status bit 0 (CHECK) of that read and `tmo` low. It is idle the cycle after.
- R8: A polling wait that goes `timeout_cycles`+1 cycles without its exit condition ends the run with `done`, `fail` and `tmo` high. No further writes are made.
- R9: `start` while busy is ignored. The packet and length in use are those sampled when the run was accepted, and `busy` stays high until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet run (accepted only when idle) |
| pkt_bytes | input | 96 | Command bytes, byte i at bits 8i+7..8i |
| long_pkt | input | 1 | 1: device takes 16-byte packets (zero padded) |
| timeout_cycles | input | 16 | Cycle limit for each polling wait |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | With `done`: device reported CHECK or a wait timed out |
| tmo | output | 1 | With `done`: a wait timed out |
| tf_req | output | 1 | Task-file access request |
| tf_we | output | 1 | Access is a write |
| tf_addr | output | 3 | Command-block register address |
| tf_wdata | output | 16 | Write data |
| tf_ack | input | 1 | Access completed |
| tf_rdata | input | 8 | Status byte, valid with `tf_ack` on reads |

## Verification
A wrong state or transition shows up at the task-file port within one or two accesses. If the state register is off, a write lands at the wrong address or goes out before the device has shown idle or data-request status. If the word index is off, a word is repeated or skipped, or the pad words come out non-zero, and the first mismatching word identifies it. A broken poll or timer shows only at `done`: a missing `tmo`, a late pulse, or a `fail` that does not match the CHECK bit. Directed runs with device models that stall, never request data, or report CHECK therefore expose each exit path within one packet.

// File: rtl/atapi_pkt_pkg.sv
package atapi_pkt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRECHK,
        S_CMD,
        S_DRQWAIT,
        S_WORD,
        S_POSTWAIT,
        S_FINISH
    } issuer_state_t;

    localparam logic [2:0]  REG_DATA   = 3'd0;
    localparam logic [2:0]  REG_STATUS = 3'd7;
    localparam logic [2:0]  REG_CMD    = 3'd7;
    localparam logic [15:0] OPC_PACKET = 16'h00A0;

    localparam int ST_BSY = 7;
    localparam int ST_DRQ = 3;
    localparam int ST_CHK = 0;

endpackage

// File: rtl/pkt_word_sel.sv
module pkt_word_sel #(
    parameter int CMD_BYTES = 12,
    parameter int IDX_W     = 3
) (
    input  logic [8*CMD_BYTES-1:0] pkt,
    input  logic [IDX_W-1:0]       idx,
    output logic [15:0]            word
);
    localparam int CMD_WORDS = CMD_BYTES / 2;

    // Word k is bytes 2k (low) and 2k+1 (high): the little-endian slice.
    // Indices beyond the command give zero padding.
    always_comb begin
        word = '0;
        for (int k = 0; k < CMD_WORDS; k++) begin
            if (idx == IDX_W'(k)) begin
                word = pkt[16*k +: 16];
            end
        end
    end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/atapi_pkt_issuer.sv
module atapi_pkt_issuer
    import atapi_pkt_pkg::*;
#(
    parameter int CMD_BYTES = 12,
    parameter int PAD_BYTES = 16,
    parameter int TMO_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [8*CMD_BYTES-1:0] pkt_bytes,
    input  logic                   long_pkt,
    input  logic [TMO_W-1:0]       timeout_cycles,
    output logic                   busy,
    output logic                   done,
    output logic                   fail,
    output logic                   tmo,
    output logic                   tf_req,
    output logic                   tf_we,
    output logic [2:0]             tf_addr,
    output logic [15:0]            tf_wdata,
    input  logic                   tf_ack,
    input  logic [7:0]             tf_rdata
);
    localparam int CMD_WORDS = CMD_BYTES / 2;
    localparam int PAD_WORDS = PAD_BYTES / 2;
    localparam int IDX_W     = $clog2(PAD_WORDS);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(CMD_WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(PAD_WORDS - 1);

    issuer_state_t state, state_nx;

    logic [8*CMD_BYTES-1:0] pkt_q;
    logic                   long_q;
    logic [IDX_W-1:0]       widx;
    logic                   fail_q, tmo_q;
    logic [15:0]            word;
    logic                   polling, expired;
    logic                   st_bsy, st_drq, st_chk;
    logic                   last_word;
    logic                   unused_status_bits;

    assign st_bsy    = tf_rdata[ST_BSY];
    assign st_drq    = tf_rdata[ST_DRQ];
    assign st_chk    = tf_rdata[ST_CHK];
    assign last_word = (widx == (long_q ? LAST_LONG : LAST_SHORT));
    assign polling   = (state == S_PRECHK) || (state == S_DRQWAIT) || (state == S_POSTWAIT);
    assign unused_status_bits = ^{tf_rdata[6:4], tf_rdata[2:1]};

    pkt_word_sel #(.CMD_BYTES(CMD_BYTES), .IDX_W(IDX_W)) u_sel (
        .pkt  (pkt_q),
        .idx  (widx),
        .word (word)
    );

    wait_timer #(.W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_nx != state),
        .run     (polling),
        .limit   (timeout_cycles),
        .expired (expired)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = S_PRECHK;
            S_PRECHK:   if (tf_ack && !st_bsy)           state_nx = S_CMD;
                        else if (expired)                state_nx = S_FINISH;
            S_CMD:      if (tf_ack)                      state_nx = S_DRQWAIT;
            S_DRQWAIT:  if (tf_ack && !st_bsy && st_drq) state_nx = S_WORD;
                        else if (expired)                state_nx = S_FINISH;
            S_WORD:     if (tf_ack && last_word)         state_nx = S_POSTWAIT;
            S_POSTWAIT: if (tf_ack && !st_bsy)           state_nx = S_FINISH;
                        else if (expired)                state_nx = S_FINISH;
            S_FINISH:   state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Run context: packet, length, word index and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_q  <= '0;
            long_q <= 1'b0;
            widx   <= '0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                pkt_q  <= pkt_bytes;
                long_q <= long_pkt;
                widx   <= '0;
                fail_q <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if (state == S_WORD && tf_ack && !last_word) begin
                widx <= widx + 1'b1;
            end
            if (polling && state_nx == S_FINISH) begin
                if (state == S_POSTWAIT && tf_ack && !st_bsy) begin
                    fail_q <= st_chk;
                end else begin
                    fail_q <= 1'b1;
                    tmo_q  <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_FINISH);
        fail     = done && fail_q;
        tmo      = done && tmo_q;
        tf_req   = 1'b0;
        tf_we    = 1'b0;
        tf_addr  = REG_STATUS;
        tf_wdata = '0;
        unique case (state)
            S_PRECHK, S_DRQWAIT, S_POSTWAIT: begin
                tf_req  = 1'b1;
                tf_addr = REG_STATUS;
            end
            S_CMD: begin
                tf_req   = 1'b1;
                tf_we    = 1'b1;
                tf_addr  = REG_CMD;
                tf_wdata = OPC_PACKET;
            end
            S_WORD: begin
                tf_req   = 1'b1;
                tf_we    = 1'b1;
                tf_addr  = REG_DATA;
                tf_wdata = word;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/atapi_pkt_issuer_chk.sv
module atapi_pkt_issuer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        tf_req,
    input logic        tf_we,
    input logic [2:0]  tf_addr,
    input logic [15:0] tf_wdata,
    input logic        tf_ack
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tf_req);

    assert_cmd_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_req && tf_we && tf_addr == 3'd7) |-> (tf_wdata == 16'h00A0));

    assert_write_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_req && tf_we) |-> (tf_addr == 3'd0 || tf_addr == 3'd7));

    assert_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_req && tf_we && !tf_ack) |=> (tf_req && tf_we && $stable(tf_addr) && $stable(tf_wdata)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
endmodule

bind atapi_pkt_issuer atapi_pkt_issuer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .tf_req   (tf_req),
    .tf_we    (tf_we),
    .tf_addr  (tf_addr),
    .tf_wdata (tf_wdata),
    .tf_ack   (tf_ack)
);

// File: tb/atapi_pkt_issuer_bench.sv
`timescale 1ns/1ps
module atapi_pkt_issuer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [95:0] pkt_in = '0;
    logic        long_in = 1'b0;
    logic [15:0] lim = 16'd40;
    logic        busy, done, fail, tmo;
    logic        tf_req, tf_we;
    logic [2:0]  tf_addr;
    logic [15:0] tf_wdata;
    logic        tf_ack;
    logic [7:0]  tf_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    atapi_pkt_issuer u_atapi_pkt_issuer (
        .clk(clk), .rst_n(rst_n), .start(start), .pkt_bytes(pkt_in),
        .long_pkt(long_in), .timeout_cycles(lim), .busy(busy), .done(done),
        .fail(fail), .tmo(tmo), .tf_req(tf_req), .tf_we(tf_we),
        .tf_addr(tf_addr), .tf_wdata(tf_wdata), .tf_ack(tf_ack),
        .tf_rdata(tf_rdata)
    );

    // ---------------- device model ----------------
    int  cfg_pre = 0, cfg_drq = 0, cfg_post = 0, cfg_words = 6;
    bit  cfg_chk = 0, cfg_nodrq = 0;
    logic model_clr = 1'b0;

    int phase, polls, wr_n, cmd_cnt, bsy_viol, drq_viol;
    bit drq_seen;
    logic [2:0]  wr_addr [0:15];
    logic [15:0] wr_data [0:15];

    always_comb begin
        if (phase == 0)      tf_rdata = (polls < cfg_pre) ? 8'h80 : 8'h40;
        else if (phase == 1) tf_rdata = cfg_nodrq ? 8'h00 : ((polls < cfg_drq) ? 8'h80 : 8'h48);
        else                 tf_rdata = (polls < cfg_post) ? 8'h80 : (8'h40 | {7'd0, cfg_chk});
    end

    always @(posedge clk) begin
        if (!rst_n || model_clr) begin
            tf_ack <= 1'b0; phase <= 0; polls <= 0; wr_n <= 0;
            cmd_cnt <= 0; bsy_viol <= 0; drq_viol <= 0; drq_seen <= 0;
        end else begin
            tf_ack <= tf_req && !tf_ack;
            if (tf_req && tf_ack) begin
                if (tf_we) begin
                    if (wr_n < 16) begin
                        wr_addr[wr_n] <= tf_addr;
                        wr_data[wr_n] <= tf_wdata;
                    end
                    wr_n <= wr_n + 1;
                    if (tf_addr == 3'd7) begin
                        cmd_cnt <= cmd_cnt + 1;
                        if (phase != 0 || polls < cfg_pre) bsy_viol <= bsy_viol + 1;
                        phase <= 1; polls <= 0;
                    end else begin
                        if (!drq_seen) drq_viol <= drq_viol + 1;
                        if (wr_n == cfg_words) begin
                            phase <= 2; polls <= 0;
                        end
                    end
                end else begin
                    polls <= polls + 1;
                    if (phase == 1 && tf_rdata[3] && !tf_rdata[7]) drq_seen <= 1;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        @(negedge clk); model_clr = 1'b1;
        @(negedge clk); model_clr = 1'b0;
    endtask

    task automatic run(input logic [95:0] p, input bit lng, input int pre, input int drq,
                       input int post, input bit chkb, input bit nodrq,
                       input logic [15:0] limit, input bit inject,
                       output bit g_fail, output bit g_tmo, output bit g_done);
        cfg_pre = pre; cfg_drq = drq; cfg_post = post; cfg_chk = chkb;
        cfg_nodrq = nodrq; cfg_words = lng ? 8 : 6;
        clear_model();
        pkt_in = p; long_in = lng; lim = limit;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (inject) begin
            repeat (5) @(negedge clk);
            pkt_in = ~p; long_in = ~lng; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        g_done = 0; g_fail = 0; g_tmo = 0;
        for (int i = 0; i < 5000 && !g_done; i++) begin
            if (done) begin
                g_done = 1; g_fail = fail; g_tmo = tmo;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
    endtask

    task automatic check_stream(input logic [95:0] p, input bit lng, input string tag);
        int nw;
        nw = lng ? 8 : 6;
        chk(wr_n == nw + 1, "R6", {tag, " write count"}, wr_n, nw + 1);
        chk(cmd_cnt == 1 && wr_addr[0] == 3'd7 && wr_data[0] == 16'h00A0, "R3",
            {tag, " command first"}, wr_data[0], 16'h00A0);
        chk(bsy_viol == 0, "R2", {tag, " command while busy"}, bsy_viol, 0);
        chk(drq_viol == 0, "R4", {tag, " data before DRQ"}, drq_viol, 0);
        for (int k = 0; k < nw; k++) begin
            logic [15:0] e;
            e = (k < 6) ? {p[16*k+8 +: 8], p[16*k +: 8]} : 16'h0000;
            chk(wr_addr[k+1] == 3'd0 && wr_data[k+1] == e, (k < 6) ? "R5" : "R6",
                {tag, " packet word"}, wr_data[k+1], e);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(!busy && !tf_req && !done, "R1", "reset idle", {busy, tf_req, done}, 0);
    endtask

    task automatic t_short();
        bit f, t, d;
        logic [95:0] p = 96'hBBAA_9988_7766_5544_3322_1100;
        run(p, 0, 3, 2, 2, 0, 0, 16'd40, 0, f, t, d);
        check_stream(p, 0, "short");
        chk(d && !f && !t, "R7", "short clean done", {d, f, t}, 3'b100);
        chk(!busy, "R7", "idle after done", busy, 0);
    endtask

    task automatic t_long();
        bit f, t, d;
        logic [95:0] p = 96'h0123_4567_89AB_CDEF_F00D_CAFE;
        run(p, 1, 0, 0, 4, 0, 0, 16'd40, 0, f, t, d);
        check_stream(p, 1, "long");
        chk(d && !f && !t, "R7", "long clean done", {d, f, t}, 3'b100);
    endtask

    task automatic t_check_bit();
        bit f, t, d;
        logic [95:0] p = 96'h5A5A_A5A5_1234_5678_9ABC_DEF0;
        run(p, 0, 1, 1, 1, 1, 0, 16'd40, 0, f, t, d);
        chk(d && f && !t, "R7", "CHECK reported as fail", {d, f, t}, 3'b110);
    endtask

    task automatic t_no_drq();
        bit f, t, d;
        run(96'h1, 0, 0, 0, 0, 0, 1, 16'd20, 0, f, t, d);
        chk(d && f && t, "R8", "DRQ timeout flags", {d, f, t}, 3'b111);
        chk(wr_n == 1, "R8", "no data after timeout", wr_n, 1);
    endtask

    task automatic t_post_stall();
        bit f, t, d;
        run(96'h2, 0, 0, 0, 1000, 0, 0, 16'd30, 0, f, t, d);
        chk(d && f && t, "R8", "final wait timeout", {d, f, t}, 3'b111);
        chk(wr_n == 7, "R8", "writes before final timeout", wr_n, 7);
    endtask

    task automatic t_pre_stall();
        bit f, t, d;
        run(96'h3, 0, 1000, 0, 0, 0, 0, 16'd25, 0, f, t, d);
        chk(d && t && wr_n == 0, "R2", "no command while BSY stays set", wr_n, 0);
    endtask

    task automatic t_restart_ignored();
        bit f, t, d;
        logic [95:0] p = 96'hFEDC_BA98_7654_3210_0F1E_2D3C;
        run(p, 0, 2, 6, 2, 0, 0, 16'd40, 1, f, t, d);
        check_stream(p, 0, "restart");
        chk(d && !f && !t, "R9", "run completes once", {d, f, t}, 3'b100);
        repeat (4) @(negedge clk);
        chk(!busy && wr_n == 7, "R9", "no second run", wr_n, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_long();
        t_check_bit();
        t_no_drq();
        t_post_stall();
        t_pre_stall();
        t_restart_ignored();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule